// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of an intermediate-frequency pulse train. It counts rising edges of the IF input during a gate window and keeps the binary result for readout. The gate window is 4, 8, 32 or 64 timebase ticks long, with one tick per millisecond. A host reads the result as a 20-bit word. Bit 19 is the most significant bit and is the first bit sent on a serial link. The frequency is the count divided by the gate time. For example, 3600 edges in an 8 ms gate is 450 kHz.

A measurement is controlled by a single start bit.
- While the start bit is low, the block sits in `ST_IDLE` and the result is zero.
- A low-to-high transition of the start bit arms a measurement and moves the block to `ST_SETTLE`. This state is a settling wait of a fixed number of ticks, chosen by the gate select.
- The block then moves to `ST_GATE`, where it counts edges for the gate length.
- The block then enters `ST_HOLD`. It keeps the result and raises `done` for as long as the start bit stays high.

The transitions are:
- `arm`: from `ST_IDLE` to `ST_SETTLE`.
- `settle_end`: from `ST_SETTLE` to `ST_GATE`.
- `gate_end`: from `ST_GATE` to `ST_HOLD`.
- `abort`: from any state to `ST_IDLE`, when the start bit is low or inhibit is high.

A completion output, `stat_low`, can drive a shared open-drain status pin low. It is set at the end of the gate. It is released by any serial transfer (`xfer` high) and by a return to idle. An inhibit input stops the block and holds it idle.

Top module: `ifc_gate_counter`

## Requirements
- R1: After reset, `count` is 0, `done` is 0 and `stat_low` is 0.
- R2: The gate length in ticks is 4, 8, 32 or 64 for `gate_sel` values 0, 1, 2 and 3. `count` equals the number of IF rising edges in that window. `count[19]` is the MSB.
- R3: The settling wait is 4 ticks for `gate_sel` 0 and 1, and 8 ticks for 2 and 3. `done` rises on the tick that completes the wait plus the gate, counted from the arm.
- R4: Edges during the settling wait and after the gate are not counted. While `start` stays 1, the result and `done` remain unchanged.
- R5: When `start` is 0, `count`, `done` and `stat_low` are 0 within two clock cycles and stay there.
- R6: A measurement begins only on a 0-to-1 transition of `start`. Holding `start` at 1 never begins a second one.
- R7: The count saturates at all ones instead of wrapping.
- R8: `stat_low` goes to 1 at the end of the gate. A cycle with `xfer` high returns it to 0 while `done` remains 1.
- R9: While `inhibit` is 1, the block is idle: `count` is 0 and `done` is 0. A start edge seen during inhibit is ignored.
- R10: `gate_sel` is captured at the arm. Later changes to it do not alter the running measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_in | input | 1 | IF pulse input, asynchronous |
| tick | input | 1 | One-cycle timebase pulse, 1 per ms |
| start | input | 1 | Measurement start bit |
| gate_sel | input | 2 | Gate select: 0=4, 1=8, 2=32, 3=64 ticks |
| inhibit | input | 1 | Stops the block and holds it idle |
| xfer | input | 1 | Serial transfer active; releases `stat_low` |
| count | output | CNT_W (20) | Measured edge count, MSB first on readout |
| done | output | 1 | Result valid and held |
| stat_low | output | 1 | 1 = pull the shared status pin low |

## Verification
The assertions assume the following about the inputs:
- `tick` is a single-cycle pulse.
- `start` changes only between clock edges.
- The IF input stays high and low for at least two clock cycles each, which keeps the rate below half the system clock.

The stimulus meets these assumptions:
- It drives all inputs at the falling clock edge.
- It places ticks 40 cycles apart.
- It uses IF periods of 4 cycles or longer that divide the tick spacing evenly. As a result, every gate window holds an exact whole number of edges whatever the synchronizer latency.
- It arms each measurement just after a tick, so the tick count to `done` is exact.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_GATE   = 2'd2,
        ST_HOLD   = 2'd3
    } ifc_state_e;
endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // STAGES synchronizer flops plus one flop for edge detection
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ifc_tick_timer.sv
module ifc_tick_timer #(
    parameter int TW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    logic [TW-1:0] cnt;

    assign expire = tick && !clr && (cnt == limit - TW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (clr || expire) cnt <= '0;
        else if (tick)         cnt <= cnt + TW'(1);
    end
endmodule

// File: rtl/ifc_sat_counter.sv
module ifc_sat_counter #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   value <= '0;
        else if (clr)                 value <= '0;
        else if (inc && value != TOP) value <= value + W'(1);
    end
endmodule

// File: rtl/ifc_gate_counter.sv
module ifc_gate_counter #(
    parameter int CNT_W       = 20,
    parameter int GATE0       = 4,
    parameter int GATE1       = 8,
    parameter int GATE2       = 32,
    parameter int GATE3       = 64,
    parameter int WAIT_SHORT  = 4,
    parameter int WAIT_LONG   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             if_in,
    input  logic             tick,
    input  logic             start,
    input  logic [1:0]       gate_sel,
    input  logic             inhibit,
    input  logic             xfer,
    output logic [CNT_W-1:0] count,
    output logic             done,
    output logic             stat_low
);
    import ifc_pkg::*;

    localparam int TMR_W = $clog2(GATE3 + 1);

    ifc_state_e       st_q, st_d;
    logic             start_q;
    logic [1:0]       sel_q;
    logic             arm, abort_req, tmr_exp, if_rise;
    logic [TMR_W-1:0] tmr_limit;

    assign arm       = start && !start_q && !inhibit;
    assign abort_req = !start || inhibit;

    // Length of the current timed phase, from the captured select
    always_comb begin
        tmr_limit = '0;
        if (st_q == ST_SETTLE) begin
            tmr_limit = sel_q[1] ? TMR_W'(WAIT_LONG) : TMR_W'(WAIT_SHORT);
        end else begin
            unique case (sel_q)
                2'd0: tmr_limit = TMR_W'(GATE0);
                2'd1: tmr_limit = TMR_W'(GATE1);
                2'd2: tmr_limit = TMR_W'(GATE2);
                2'd3: tmr_limit = TMR_W'(GATE3);
            endcase
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (st_q != ST_IDLE && abort_req) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:   if (arm)     st_d = ST_SETTLE;
                ST_SETTLE: if (tmr_exp) st_d = ST_GATE;
                ST_GATE:   if (tmr_exp) st_d = ST_HOLD;
                ST_HOLD:                st_d = ST_HOLD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Registered outputs and captured controls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q  <= 1'b0;
            sel_q    <= 2'd0;
            stat_low <= 1'b0;
        end else begin
            start_q <= start;
            if (st_q == ST_IDLE && arm) sel_q <= gate_sel;
            if (st_q == ST_GATE && st_d == ST_HOLD)  stat_low <= 1'b1;
            else if (xfer || st_q == ST_IDLE)        stat_low <= 1'b0;
        end
    end

    assign done = (st_q == ST_HOLD);

    ifc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (if_in),
        .rise (if_rise)
    );

    ifc_tick_timer #(.TW(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st_q == ST_IDLE || st_q == ST_HOLD),
        .tick  (tick),
        .limit (tmr_limit),
        .expire(tmr_exp)
    );

    ifc_sat_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (st_q == ST_IDLE),
        .inc  (if_rise && st_q == ST_GATE),
        .value(count)
    );
endmodule

// File: rtl/ifc_gate_counter_chk.sv
module ifc_gate_counter_chk #(
    parameter int CNT_W = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                xfer,
    input logic                tick,
    input ifc_pkg::ifc_state_e st_q,
    input logic [CNT_W-1:0]    count,
    input logic                done,
    input logic                stat_low
);
    import ifc_pkg::*;

    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_GATE) |=> (count >= $past(count)));

    // R4
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HOLD && $past(st_q) == ST_HOLD) |-> $stable(count));

    // R3
    done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(tick));

    // R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start) && !$past(start, 2)) |-> (count == '0 && !done));

    // R8
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_low) |-> ($past(xfer) || $past(st_q) == ST_IDLE));

    // R8
    set_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_low) |-> $rose(done));
endmodule

bind ifc_gate_counter ifc_gate_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .xfer    (xfer),
    .tick    (tick),
    .st_q    (st_q),
    .count   (count),
    .done    (done),
    .stat_low(stat_low)
);

// File: tb/tb_ifc_gate_counter.sv
`timescale 1ns/1ps
module tb_ifc_gate_counter;
    localparam int TICK_CYC = 40;
    localparam int NVEC     = 6;
    // {gate_sel, IF period in cycles, expected count}
    localparam int VEC [NVEC][3] = '{
        '{0, 4, 40}, '{1, 5, 64}, '{2, 8, 160},
        '{3, 4, 640}, '{0, 0, 0}, '{1, 20, 16}
    };

    logic        clk = 0, rst_n = 0, if_in = 0, tick = 0, start = 0;
    logic        inhibit = 0, xfer = 0;
    logic [1:0]  gate_sel = 0;
    logic [19:0] count;
    logic [7:0]  count_s;
    logic        done, stat_low, done_s, stat_low_s;
    int          if_per = 0;
    int          errors = 0, checks = 0;

    always #2 clk = ~clk;

    ifc_gate_counter dut (
        .clk(clk), .rst_n(rst_n), .if_in(if_in), .tick(tick), .start(start),
        .gate_sel(gate_sel), .inhibit(inhibit), .xfer(xfer),
        .count(count), .done(done), .stat_low(stat_low));

    ifc_gate_counter #(.CNT_W(8)) dut_sat (
        .clk(clk), .rst_n(rst_n), .if_in(if_in), .tick(tick), .start(start),
        .gate_sel(gate_sel), .inhibit(inhibit), .xfer(xfer),
        .count(count_s), .done(done_s), .stat_low(stat_low_s));

    initial begin
        forever begin
            repeat (TICK_CYC - 1) @(negedge clk);
            tick = 1;
            @(negedge clk);
            tick = 0;
        end
    end

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            if (if_per == 0) if_in = 0;
            else begin
                ph = (ph + 1) % if_per;
                if_in = (ph < if_per / 2);
            end
        end
    end

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..: actual=timeout expected=finish");
        summary();
        $finish;
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int total_ticks(input int sel);
        int g;
        case (sel)
            0: g = 4;  1: g = 8;  2: g = 32;  default: g = 64;
        endcase
        return g + ((sel >= 2) ? 8 : 4);
    endfunction

    task automatic align_tick();
        int guard = 0;
        do begin step(); guard++; end while (!tick && guard < 200);
    endtask

    // Arms a measurement and returns ticks seen until done
    task automatic measure(input int sel, input int per, input int late_sel,
                           output int nt);
        int guard = 0;
        if_per = per;
        gate_sel = 2'(sel);
        @(negedge clk) start = 0;
        repeat (3) step();
        align_tick();
        @(negedge clk) start = 1;
        nt = 0;
        while (guard < 5000) begin
            step();
            guard++;
            if (guard == 2) gate_sel = 2'(late_sel);
            if (tick) nt++;
            if (done) break;
        end
    endtask

    initial begin
        int nt;
        int cap;
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        check("R1 count", int'(count), 0);
        check("R1 done", int'(done), 0);
        check("R1 stat_low", int'(stat_low), 0);

        for (int v = 0; v < NVEC; v++) begin
            measure(VEC[v][0], VEC[v][1], VEC[v][0], nt);
            check("R3 ticks to done", nt, total_ticks(VEC[v][0]));
            check("R2 count", int'(count), VEC[v][2]);
            cap = (VEC[v][2] > 255) ? 255 : VEC[v][2];
            check("R7 saturated count", int'(count_s), cap);
            check("R8 stat_low set", int'(stat_low), 1);
            repeat (3 * TICK_CYC) step();
            check("R4 held count", int'(count), VEC[v][2]);
            check("R6 no restart, done held", int'(done), 1);
            @(negedge clk) xfer = 1;
            @(negedge clk) xfer = 0;
            step();
            check("R8 released by xfer", int'(stat_low), 0);
            check("R8 done after xfer", int'(done), 1);
        end

        // R5: start cleared
        @(negedge clk) start = 0;
        step(); step();
        check("R5 count cleared", int'(count), 0);
        check("R5 done cleared", int'(done), 0);

        // R10: select changed during the settling wait
        measure(0, 4, 3, nt);
        check("R10 ticks", nt, total_ticks(0));
        check("R10 count", int'(count), 40);

        // R9: inhibit mid-gate, then start held without a new edge
        @(negedge clk) start = 0;
        gate_sel = 2'd3;
        repeat (3) step();
        align_tick();
        @(negedge clk) start = 1;
        repeat (20 * TICK_CYC) step();
        @(negedge clk) inhibit = 1;
        step(); step();
        check("R9 count under inhibit", int'(count), 0);
        check("R9 done under inhibit", int'(done), 0);
        @(negedge clk) start = 0;
        step();
        @(negedge clk) start = 1;
        repeat (5 * TICK_CYC) step();
        check("R9 start edge ignored", int'(done), 0);
        @(negedge clk) inhibit = 0;
        repeat (80 * TICK_CYC) step();
        check("R6 no measurement without edge", int'(done), 0);
        check("R6 count idle", int'(count), 0);

        summary();
        $finish;
    end
endmodule